// File: doc/BRIEF.md
# Reed-Solomon Framer with Attached Sync Mark

The block turns a stream of 9-bit words into coded frames for a link that cannot retransmit. A frame opens with four fixed synchronisation words. Next come 479 information words, copied to the output unchanged. The frame closes with 32 check words from a systematic Reed-Solomon encoder over GF(2^9). The encoder is a feedback shift register that absorbs each information word as it passes.

The upstream source presents a word together with a new-data strobe. The block accepts that word only while it raises its ready output. While the sync words go out, the block raises a sync-phase flag, and ready stays low through both the sync phase and the check phase. Every emitted word comes with a one-cycle write enable.

Top module: `rs_sync_framer`

## Requirements
- R1: After reset the output sequence repeats the same frame: 4 sync words, then 479 information words, then 32 check words, 515 written words per frame in that order.
- R2: An information word accepted at a clock edge (ready and strobe both high) appears on `dout` with `dout_we` high after the next clock edge, with its value unchanged.
- R3: The sync words are emitted on consecutive cycles in the order `SYNC_W0`, `SYNC_W1`, `SYNC_W2`, `SYNC_W3`, with default values 0x1A5, 0x0F3, 0x156, 0x0C9.
- R4: `din_ready` is high only in the information phase. From the edge that accepts the 479th information word, `din_ready` stays low for exactly 36 cycles: 32 check cycles, then 4 sync cycles.
- R5: `sync_phase` is high for exactly 4 consecutive cycles per frame, including the first frame after reset, and never while `din_ready` is high.
- R6: `dout_we` is high only for emitted words. A cycle in the information phase with the strobe low produces no output word.
- R7: The check words are the remainder of m(x)·x^32 divided by g(x). Here m(x) has the first information word as its highest coefficient. The field polynomial is x^9+x^4+1, g(x) is the product of (x + α^i) for i = 0 to 31, and α = 0x002. The 32 check words go out on consecutive cycles, highest-degree coefficient first.
- R8: For each codeword of 511 words (the information words followed by the check words), the evaluation at α^j is zero for every j from 0 to 31.
- R9: While reset is held, `dout_we` = 0, `dout` = 0, `sync_phase` = 1 and `din_ready` = 0.
- R10: A strobe raised while `din_ready` is low is ignored: no word is emitted for it and the check words are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 9 | Information word from upstream |
| din_nd | input | 1 | New-data strobe qualifying `din` |
| din_ready | output | 1 | High when an information word can be accepted |
| sync_phase | output | 1 | High while the sync mark is being emitted |
| dout | output | 9 | Emitted word |
| dout_we | output | 1 | Write enable qualifying `dout` |

## Verification
Two functions can land in the same cycle. The parity register absorbs the 479th information word at the same clock edge at which the sequencer leaves the information phase. The bench provokes this by strobing every cycle in one frame and with gaps in another. It judges the result by comparing the first check word, and the whole codeword's syndromes, against a reference long division. A strobe may also arrive at the very edge where the phase changes to check or sync. One frame therefore holds the strobe high with changing data throughout the non-ready window, and the scoreboard must see neither extra words nor altered check words.

// File: rtl/rsf_pkg.sv
package rsf_pkg;

    localparam int SYM_W   = 9;
    localparam int MAX_PAR = 64;
    localparam logic [SYM_W:0] FIELD_POLY = 10'h211;   // x^9 + x^4 + 1

    typedef logic [SYM_W-1:0] sym_t;

    typedef enum logic [1:0] {
        PH_SYNC = 2'd0,
        PH_DATA = 2'd1,
        PH_PAR  = 2'd2
    } phase_e;

    typedef struct packed {
        sym_t word;
        logic we;
    } out_t;

    // Multiply two field elements, shift-and-add with modular reduction
    function automatic sym_t gf_mul(sym_t a, sym_t b);
        sym_t acc;
        sym_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh[SYM_W-1] ? ((sh << 1) ^ FIELD_POLY[SYM_W-1:0]) : (sh << 1);
        end
        return acc;
    endfunction

    // Generator coefficients g[0..npar-1] (ascending, monic term dropped),
    // roots alpha^0 .. alpha^(npar-1)
    function automatic logic [SYM_W*MAX_PAR-1:0] gen_poly(int npar);
        sym_t g [MAX_PAR+1];
        sym_t root;
        logic [SYM_W*MAX_PAR-1:0] flat;
        for (int k = 0; k <= MAX_PAR; k++) g[k] = '0;
        g[0] = sym_t'(1);
        root = sym_t'(1);
        for (int i = 0; i < npar; i++) begin
            for (int k = MAX_PAR; k > 0; k--) g[k] = g[k-1] ^ gf_mul(g[k], root);
            g[0] = gf_mul(g[0], root);
            root = gf_mul(root, sym_t'(2));
        end
        flat = '0;
        for (int k = 0; k < MAX_PAR; k++) flat[k*SYM_W +: SYM_W] = g[k];
        return flat;
    endfunction

endpackage

// File: rtl/rsf_seq.sv
module rsf_seq import rsf_pkg::*; #(
    parameter int DATA_WORDS = 479,
    parameter int PAR_WORDS  = 32,
    parameter int SYNC_WORDS = 4,
    localparam int CNT_W = $clog2(DATA_WORDS),
    localparam int SEL_W = $clog2(SYNC_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    output phase_e           phase,
    output logic [SEL_W-1:0] sync_sel
);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            PH_SYNC: begin
                if (s_q.cnt == CNT_W'(SYNC_WORDS-1)) begin
                    s_d.phase = PH_DATA;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_DATA: begin
                if (accept) begin
                    if (s_q.cnt == CNT_W'(DATA_WORDS-1)) begin
                        s_d.phase = PH_PAR;
                        s_d.cnt   = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            PH_PAR: begin
                if (s_q.cnt == CNT_W'(PAR_WORDS-1)) begin
                    s_d.phase = PH_SYNC;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d = '{phase: PH_SYNC, cnt: '0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{phase: PH_SYNC, cnt: '0};
        else        s_q <= s_d;
    end

    assign phase    = s_q.phase;
    assign sync_sel = s_q.cnt[SEL_W-1:0];

endmodule

// File: rtl/rsf_parity.sv
module rsf_parity import rsf_pkg::*; #(
    parameter int NPAR = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic absorb,
    input  logic shift,
    input  sym_t din,
    output sym_t top
);

    localparam logic [SYM_W*MAX_PAR-1:0] GEN = gen_poly(NPAR);

    sym_t [NPAR-1:0] par_d, par_q, prod;
    sym_t fb;

    assign fb = din ^ par_q[NPAR-1];

    for (genvar i = 0; i < NPAR; i++) begin : g_tap
        assign prod[i] = gf_mul(fb, GEN[i*SYM_W +: SYM_W]);
    end

    always_comb begin
        par_d = par_q;
        if (absorb) begin
            par_d[0] = prod[0];
            for (int i = 1; i < NPAR; i++) par_d[i] = par_q[i-1] ^ prod[i];
        end else if (shift) begin
            par_d[0] = '0;
            for (int i = 1; i < NPAR; i++) par_d[i] = par_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) par_q <= '0;
        else        par_q <= par_d;
    end

    assign top = par_q[NPAR-1];

endmodule

// File: rtl/rs_sync_framer.sv
module rs_sync_framer import rsf_pkg::*; #(
    parameter int   DATA_WORDS = 479,
    parameter int   PAR_WORDS  = 32,
    parameter sym_t SYNC_W0    = 9'h1A5,
    parameter sym_t SYNC_W1    = 9'h0F3,
    parameter sym_t SYNC_W2    = 9'h156,
    parameter sym_t SYNC_W3    = 9'h0C9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [8:0] din,
    input  logic       din_nd,
    output logic       din_ready,
    output logic       sync_phase,
    output logic [8:0] dout,
    output logic       dout_we
);

    localparam int SYNC_WORDS = 4;
    localparam int SEL_W      = $clog2(SYNC_WORDS);

    phase_e           phase;
    logic [SEL_W-1:0] sync_sel;
    logic             accept;
    sym_t             par_top;
    sym_t             sync_word;
    out_t             o_d, o_q;

    assign din_ready  = (phase == PH_DATA);
    assign sync_phase = (phase == PH_SYNC);
    assign accept     = din_ready & din_nd;

    rsf_seq #(
        .DATA_WORDS (DATA_WORDS),
        .PAR_WORDS  (PAR_WORDS),
        .SYNC_WORDS (SYNC_WORDS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .phase    (phase),
        .sync_sel (sync_sel)
    );

    rsf_parity #(
        .NPAR (PAR_WORDS)
    ) u_par (
        .clk    (clk),
        .rst_n  (rst_n),
        .absorb (accept),
        .shift  (phase == PH_PAR),
        .din    (din),
        .top    (par_top)
    );

    always_comb begin
        unique case (sync_sel)
            2'd0:    sync_word = SYNC_W0;
            2'd1:    sync_word = SYNC_W1;
            2'd2:    sync_word = SYNC_W2;
            default: sync_word = SYNC_W3;
        endcase
    end

    always_comb begin
        o_d.word = o_q.word;
        o_d.we   = 1'b0;
        unique case (phase)
            PH_SYNC: o_d = '{word: sync_word, we: 1'b1};
            PH_DATA: if (accept) o_d = '{word: din, we: 1'b1};
            PH_PAR:  o_d = '{word: par_top, we: 1'b1};
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign dout    = o_q.word;
    assign dout_we = o_q.we;

endmodule

// File: rtl/rsf_checker.sv
module rsf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [8:0] din,
    input logic       din_nd,
    input logic       din_ready,
    input logic       sync_phase,
    input logic [8:0] dout,
    input logic       dout_we
);

    logic [2:0] sync_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          sync_run_q <= '0;
        else if (sync_phase) sync_run_q <= sync_run_q + 3'd1;
        else                 sync_run_q <= '0;
    end

    AST_READY_NOT_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !(din_ready && sync_phase));                                    // R4
    AST_SYNC_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
        sync_phase |=> dout_we);                                        // R3
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (din_ready && din_nd) |=> (dout_we && dout == $past(din)));     // R2
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (din_ready && !din_nd) |=> !dout_we);                           // R6
    AST_SYNC_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        sync_run_q <= 3'd4);                                            // R5
    AST_SYNC_TO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_phase) |-> din_ready);                               // R1

endmodule

bind rs_sync_framer rsf_checker u_chk (.*);

// File: tb/tb_rs_sync_framer.sv
module tb_rs_sync_framer;

    localparam int K = 479;
    localparam int P = 32;
    localparam int N = K + P;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [8:0] din;
    logic       din_nd;
    logic       din_ready;
    logic       sync_phase;
    logic [8:0] dout;
    logic       dout_we;

    always #2 clk = ~clk;

    rs_sync_framer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (din),
        .din_nd     (din_nd),
        .din_ready  (din_ready),
        .sync_phase (sync_phase),
        .dout       (dout),
        .dout_we    (dout_we)
    );

    int checks = 0;
    int errors = 0;
    logic [8:0] exp_q[$];
    string      tag_q[$];
    logic [8:0] gdesc[P+1];
    logic [8:0] msg[K];
    logic [8:0] rem[N];
    logic [8:0] cw[N];
    int         cwn = 0;
    bit         done = 1'b0;

    function automatic logic [8:0] xt(logic [8:0] a);
        return a[8] ? ((a << 1) ^ 9'h011) : (a << 1);
    endfunction

    function automatic logic [8:0] tmul(logic [8:0] a, logic [8:0] b);
        logic [8:0] acc = '0;
        for (int i = 8; i >= 0; i--) begin
            acc = xt(acc);
            if (b[i]) acc = acc ^ a;
        end
        return acc;
    endfunction

    task automatic check(input bit ok, input string req, input int got, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %0h exp %0h", req, got, expv);
        end
    endtask

    task automatic push(input logic [8:0] w, input string t);
        exp_q.push_back(w);
        tag_q.push_back(t);
    endtask

    task automatic push_sync();
        push(9'h1A5, "R3"); push(9'h0F3, "R3");
        push(9'h156, "R3"); push(9'h0C9, "R3");
    endtask

    task automatic build_gen();
        logic [8:0] asc[P+1];
        logic [8:0] r = 9'h001;
        for (int k = 0; k <= P; k++) asc[k] = '0;
        asc[0] = 9'h001;
        for (int i = 0; i < P; i++) begin
            for (int k = P; k > 0; k--) asc[k] = asc[k-1] ^ tmul(asc[k], r);
            asc[0] = tmul(asc[0], r);
            r = tmul(r, 9'h002);
        end
        for (int j = 0; j <= P; j++) gdesc[j] = asc[P-j];
    endtask

    // R7 reference: polynomial long division
    task automatic push_parity();
        logic [8:0] c;
        for (int i = 0; i < N; i++) rem[i] = (i < K) ? msg[i] : 9'h000;
        for (int i = 0; i < K; i++) begin
            c = rem[i];
            if (c != 0)
                for (int j = 1; j <= P; j++) rem[i+j] = rem[i+j] ^ tmul(c, gdesc[j]);
        end
        for (int k = 0; k < P; k++) push(rem[K+k], "R7");
    endtask

    // scoreboard monitor
    initial begin
        logic [8:0] e;
        logic [8:0] s;
        logic [8:0] root;
        string t;
        forever begin
            @(negedge clk);
            if (rst_n && dout_we) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected word", dout, 0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(dout == e, t, dout, e);
                    if (t != "R3") begin
                        cw[cwn] = dout;
                        cwn++;
                        if (cwn == N) begin
                            root = 9'h001;
                            for (int j = 0; j < P; j++) begin
                                s = '0;
                                for (int i = 0; i < N; i++) s = tmul(s, root) ^ cw[i];
                                check(s == 0, "R8 syndrome", s, 0);
                                root = tmul(root, 9'h002);
                            end
                            cwn = 0;
                        end
                    end
                end
            end
        end
    end

    // driver
    initial begin
        int lowc;
        int sc;
        int n;
        int cyc;
        logic [8:0] lf;
        build_gen();
        rst_n = 1'b0; din = '0; din_nd = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(dout_we == 1'b0,    "R9 we",    dout_we, 0);
        check(dout == 9'h000,     "R9 dout",  dout, 0);
        check(sync_phase == 1'b1, "R9 sync",  sync_phase, 1);
        check(din_ready == 1'b0,  "R9 ready", din_ready, 0);
        rst_n = 1'b1;
        push_sync();
        lf = 9'h0A3;
        cyc = 0;
        for (int f = 0; f < 3; f++) begin
            lowc = 0; sc = 0;
            while (!din_ready) begin
                lowc++;
                if (sync_phase) sc++;
                din_nd = (f == 2);            // R10 strobes while not ready
                din = 9'h1FF ^ 9'(lowc);
                @(negedge clk);
            end
            check(lowc == ((f == 0) ? 4 : 36), "R4 ready-low span", lowc, (f == 0) ? 4 : 36);
            check(sc == 4, "R5 sync span", sc, 4);
            n = 0;
            while (n < K) begin
                cyc++;
                check(!sync_phase, "R5 sync during data", sync_phase, 0);
                if (f == 1 && (cyc % 3) == 0) begin
                    din_nd = 1'b0;                // R6 idle cycle
                    din = 9'h155;
                end else begin
                    if (f == 0)      din = 9'(n * 7 + 3);
                    else if (f == 1) begin
                        lf = {lf[7:0], lf[8] ^ lf[4]};
                        din = lf;
                    end else         din = n[0] ? 9'h000 : 9'h1FF;
                    din_nd = 1'b1;
                    msg[n] = din;
                    push(din, "R2");
                    n++;
                end
                @(negedge clk);
            end
            push_parity();
            push_sync();
        end
        din_nd = 1'b0;
        repeat (40) @(negedge clk);
        check(exp_q.size() == 0, "R1 frame drained", exp_q.size(), 0);
        check(din_ready == 1'b1, "R1 back in data phase", din_ready, 1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R1 watchdog", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule